// File: doc/BRIEF.md
# Complex/Simple Decoder Slot Allocator

This block sits between an instruction buffer and three parallel decoders in a wide front end. Each cycle the buffer presents up to three aligned instructions in program order, each tagged with the number of micro-ops it expands to. The allocator steers them onto one complex decoder slot and two simple decoder slots. It tells the buffer how many instructions it took, so the buffer can move its read pointer forward in the same cycle.

Slot 0 is the complex decoder. It takes any instruction of up to four micro-ops. Slots 1 and 2 are simple decoders and take only single-micro-op instructions. The group ends at the first instruction that does not fit its slot. An instruction longer than the complex decoder can handle is handed to a microsequencer. The microsequencer then puts out its micro-ops in chunks over several cycles, and takes nothing new from the buffer until the last chunk has gone out. A downstream stall freezes everything.

Top module: `uop_slot_steer`

## Requirements
- R1: During reset and in the first cycle after it, `slotValid`, `uopCount` and `fromSeq` are all zero.
- R2: A valid lane-0 instruction with a micro-op count from 1 to 4 is accepted into slot 0 (bit 0 of `slotValid`, bits [15:0] of `slotData`).
- R3: Lanes 1 and 2 are accepted into slots 1 and 2 only if their count is exactly 1 and every earlier lane was accepted. The group stops at the first lane that is invalid or does not fit, and that lane and all later lanes stay in the buffer.
- R4: `uopCount` is the sum of the micro-op counts of the accepted instructions and never exceeds 6.
- R5: A lane-0 instruction with a count above 4 is consumed alone. For that instruction the microsequencer presents min(remaining, 4) micro-ops per cycle, with `fromSeq`=1, `slotValid`=3'b001, and the instruction held in slot 0, until the count is used up.
- R6: While a micro-op sequence is in progress `consumed` is 0. Normal allocation resumes in the cycle that follows the registering of the final chunk.
- R7: While `stallIn` is high, `consumed` is 0 and all registered outputs, including the microsequencer position, keep their values.
- R8: `consumed` (0 to 3) equals the number of lanes accepted in the current cycle and is driven combinationally every cycle.
- R9: The allocation decided in a cycle appears on the slot outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stallIn | input | 1 | Downstream stall; freezes the allocator |
| inValid | input | 3 | Per-lane valid from the buffer, lane 0 oldest |
| inData | input | 48 | Instruction payload, 16 bits per lane, lane 0 in bits [15:0] |
| inUops | input | 15 | Micro-op count, 5 bits per lane, lane 0 in bits [4:0] |
| consumed | output | 2 | Lanes taken this cycle |
| slotValid | output | 3 | Slot occupancy, bit 0 complex slot |
| slotData | output | 48 | Payload per slot, 16 bits each |
| uopCount | output | 3 | Micro-ops issued in this output group |
| fromSeq | output | 1 | Output group comes from the microsequencer |

## Verification
The hardest situation to reach is a stall that lands in the middle of a micro-op sequence while the buffer already holds single-micro-op instructions behind the long one. This is what shows whether the sequence position holds and whether decoding resumes in exactly the right cycle. A directed case accepts a ten-micro-op instruction, raises the stall for two cycles after its first chunk, and checks the chunk sizes 4, 4 and 2 and the cycle in which the buffer is consumed again. A random phase mixes long instructions with random stalls and random buffer occupancy, and a behavioural model follows the outcome cycle by cycle.

// File: rtl/uss_pkg.sv
package uss_pkg;
  localparam int LANES = 3;

  typedef struct packed {
    logic [LANES-1:0] take;
    logic             seqIssue;
    logic             hold;
  } steer_ctrl_t;
endpackage

// File: rtl/uss_ctrl.sv
module uss_ctrl
  import uss_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int COMPLEX_MAX = 4,
  parameter int SEQ_RATE    = 4,
  parameter int CONS_W      = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   stallIn,
  input  logic [LANES-1:0]       inValid,
  input  logic [LANES*CNT_W-1:0] inUops,
  output steer_ctrl_t            strobe,
  output logic [CNT_W-1:0]       seqChunk,
  output logic [CONS_W-1:0]      consumed
);
  logic [CNT_W-1:0] remaining, remainingNext;
  logic             active;
  logic [CNT_W-1:0] lead;
  logic             leadLong;
  logic [LANES-1:0] chain;

  assign active   = (remaining != '0);
  assign lead     = inUops[CNT_W-1:0];
  assign leadLong = inValid[0] && (lead > CNT_W'(COMPLEX_MAX));
  assign chain[0] = inValid[0] && !leadLong;

  generate
    for (genvar i = 1; i < LANES; i++) begin : g_simple
      assign chain[i] = chain[i-1] && inValid[i] &&
                        (inUops[i*CNT_W +: CNT_W] == CNT_W'(1));
    end
  endgenerate

  function automatic logic [CNT_W-1:0] capChunk(input logic [CNT_W-1:0] left);
    return (left > CNT_W'(SEQ_RATE)) ? CNT_W'(SEQ_RATE) : left;
  endfunction

  always_comb begin
    strobe        = '0;
    strobe.hold   = stallIn;
    seqChunk      = '0;
    remainingNext = remaining;
    if (!stallIn) begin
      if (active) begin
        strobe.seqIssue = 1'b1;
        seqChunk        = capChunk(remaining);
        remainingNext   = remaining - seqChunk;
      end else if (leadLong) begin
        strobe.take[0]  = 1'b1;
        strobe.seqIssue = 1'b1;
        seqChunk        = capChunk(lead);
        remainingNext   = lead - seqChunk;
      end else begin
        strobe.take = chain;
      end
    end
  end

  always_comb begin
    consumed = '0;
    for (int i = 0; i < LANES; i++) begin
      consumed = consumed + CONS_W'(strobe.take[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) remaining <= '0;
    else       remaining <= remainingNext;
  end
endmodule

// File: rtl/uss_datapath.sv
module uss_datapath
  import uss_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5,
  parameter int SUM_W  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  steer_ctrl_t             strobe,
  input  logic [CNT_W-1:0]        seqChunk,
  input  logic [LANES*DATA_W-1:0] inData,
  input  logic [LANES*CNT_W-1:0]  inUops,
  output logic [LANES-1:0]        slotValid,
  output logic [LANES*DATA_W-1:0] slotData,
  output logic [SUM_W-1:0]        uopCount,
  output logic                    fromSeq
);
  logic [CNT_W-1:0] groupSum;
  logic [SUM_W-1:0] countNext;

  always_comb begin
    groupSum = '0;
    for (int i = 0; i < LANES; i++) begin
      if (strobe.take[i]) groupSum = groupSum + inUops[i*CNT_W +: CNT_W];
    end
    countNext = strobe.seqIssue ? SUM_W'(seqChunk) : SUM_W'(groupSum);
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_slot
      logic seqHere;
      assign seqHere = (i == 0) && strobe.seqIssue;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotValid[i]                 <= 1'b0;
          slotData[i*DATA_W +: DATA_W] <= '0;
        end else if (!strobe.hold) begin
          slotValid[i] <= strobe.take[i] | seqHere;
          if (strobe.take[i]) slotData[i*DATA_W +: DATA_W] <= inData[i*DATA_W +: DATA_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uopCount <= '0;
      fromSeq  <= 1'b0;
    end else if (!strobe.hold) begin
      uopCount <= countNext;
      fromSeq  <= strobe.seqIssue;
    end
  end
endmodule

// File: rtl/uop_slot_steer.sv
module uop_slot_steer
  import uss_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 5,
  parameter int COMPLEX_MAX = 4,
  parameter int SEQ_RATE    = 4,
  localparam int PEAK       = (COMPLEX_MAX + LANES - 1 > SEQ_RATE) ? COMPLEX_MAX + LANES - 1 : SEQ_RATE,
  localparam int SUM_W      = $clog2(PEAK + 1),
  localparam int CONS_W     = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stallIn,
  input  logic [LANES-1:0]        inValid,
  input  logic [LANES*DATA_W-1:0] inData,
  input  logic [LANES*CNT_W-1:0]  inUops,
  output logic [CONS_W-1:0]       consumed,
  output logic [LANES-1:0]        slotValid,
  output logic [LANES*DATA_W-1:0] slotData,
  output logic [SUM_W-1:0]        uopCount,
  output logic                    fromSeq
);
  steer_ctrl_t      strobe;
  logic [CNT_W-1:0] seqChunk;

  uss_ctrl #(
    .CNT_W(CNT_W), .COMPLEX_MAX(COMPLEX_MAX), .SEQ_RATE(SEQ_RATE), .CONS_W(CONS_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .stallIn(stallIn), .inValid(inValid), .inUops(inUops),
    .strobe(strobe), .seqChunk(seqChunk), .consumed(consumed)
  );

  uss_datapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SUM_W(SUM_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .seqChunk(seqChunk),
    .inData(inData), .inUops(inUops), .slotValid(slotValid), .slotData(slotData),
    .uopCount(uopCount), .fromSeq(fromSeq)
  );
endmodule

// File: rtl/uss_checker.sv
module uss_checker
  import uss_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 5,
  parameter int COMPLEX_MAX = 4,
  parameter int SUM_W       = 3,
  parameter int CONS_W      = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    stallIn,
  input logic [LANES-1:0]        inValid,
  input logic [LANES*DATA_W-1:0] inData,
  input logic [LANES*CNT_W-1:0]  inUops,
  input logic [CONS_W-1:0]       consumed,
  input logic [LANES-1:0]        slotValid,
  input logic [LANES*DATA_W-1:0] slotData,
  input logic [SUM_W-1:0]        uopCount,
  input logic                    fromSeq
);
  a_r4_peak_uops: assert property (@(posedge clk) disable iff (!rstN)
    32'(uopCount) <= COMPLEX_MAX + LANES - 1);

  a_r7_no_take_in_stall: assert property (@(posedge clk) disable iff (!rstN)
    stallIn |-> consumed == '0);

  a_r7_freeze: assert property (@(posedge clk) disable iff (!rstN)
    stallIn |=> $stable(slotValid) && $stable(uopCount) && $stable(fromSeq) && $stable(slotData));

  a_r5_seq_alone: assert property (@(posedge clk) disable iff (!rstN)
    fromSeq |-> slotValid == LANES'(1));

  a_r8_bounded_take: assert property (@(posedge clk) disable iff (!rstN)
    32'(consumed) <= $countones(inValid));

  a_r9_take_shows_next: assert property (@(posedge clk) disable iff (!rstN)
    (consumed != '0) |=> slotValid[0]);

  generate
    for (genvar i = 1; i < LANES; i++) begin : g_order
      a_r3_in_order: assert property (@(posedge clk) disable iff (!rstN)
        slotValid[i] |-> slotValid[i-1] && !fromSeq);
    end
  endgenerate
endmodule

bind uop_slot_steer uss_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .COMPLEX_MAX(COMPLEX_MAX), .SUM_W(SUM_W), .CONS_W(CONS_W)
) chk_i (.*);

// File: tb/uop_slot_steer_tb_top.sv
module uop_slot_steer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 5;
  localparam int LANES  = 3;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    stallIn = 1'b0;
  logic [LANES-1:0]        inValid = '0;
  logic [LANES*DATA_W-1:0] inData = '0;
  logic [LANES*CNT_W-1:0]  inUops = '0;
  logic [1:0]              consumed;
  logic [LANES-1:0]        slotValid;
  logic [LANES*DATA_W-1:0] slotData;
  logic [2:0]              uopCount;
  logic                    fromSeq;

  uop_slot_steer dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [DATA_W-1:0] d; int u; } ins_t;
  ins_t q[$];

  int compared = 0, mismatched = 0;
  int seqLeft = 0;
  logic [LANES-1:0] eValid = '0;
  logic [DATA_W-1:0] eData [LANES];
  int eCnt = 0;
  bit eSeq = 0;
  string outTag = "R1";
  int availMax = 3;
  bit stallReq = 0;

  function automatic void check(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endfunction

  function automatic void compareOutputs();
    check(outTag, "slotValid", slotValid, eValid);
    check(outTag, "uopCount", uopCount, eCnt);
    check(outTag, "fromSeq", fromSeq, eSeq);
    for (int i = 0; i < LANES; i++)
      if (eValid[i]) check(outTag, "slotData", slotData[i*DATA_W +: DATA_W], eData[i]);
  endfunction

  function automatic void push(int u);
    ins_t x;
    x.d = DATA_W'($urandom);
    x.u = u;
    q.push_back(x);
  endfunction

  // One cycle: at the falling edge compare, drive, model, then wait for the next falling edge.
  task automatic step();
    int n, cons, chunk, sum;
    string cTag;
    compareOutputs();
    n = (q.size() < availMax) ? q.size() : availMax;
    inValid = '0; inData = '0; inUops = '0;
    for (int i = 0; i < n; i++) begin
      inValid[i] = 1'b1;
      inData[i*DATA_W +: DATA_W] = q[i].d;
      inUops[i*CNT_W +: CNT_W] = CNT_W'(q[i].u);
    end
    stallIn = stallReq;
    #1;
    cons = 0;
    if (stallReq) begin
      cTag = "R7";  // frozen: outputs and sequence position held
      outTag = "R7";
    end else if (seqLeft > 0) begin
      cTag = "R6";
      chunk = (seqLeft > 4) ? 4 : seqLeft;
      seqLeft -= chunk;
      eValid = 3'b001; eCnt = chunk; eSeq = 1;
      outTag = "R5";
    end else begin
      cTag = "R8";
      eSeq = 0;
      if (n >= 1 && q[0].u > 4) begin
        cons = 1;
        chunk = 4;
        seqLeft = q[0].u - chunk;
        eData[0] = q[0].d;
        eValid = 3'b001; eCnt = chunk; eSeq = 1;
        outTag = "R5";
      end else if (n >= 1) begin
        cons = 1; sum = q[0].u; eData[0] = q[0].d;
        while (cons < n && q[cons].u == 1) begin
          eData[cons] = q[cons].d;
          sum += 1;
          cons++;
        end
        eValid = '0;
        for (int i = 0; i < cons; i++) eValid[i] = 1'b1;
        eCnt = sum;
        outTag = (cons > 1) ? "R3" : "R2";
      end else begin
        eValid = '0; eCnt = 0;
        outTag = "R9";
      end
    end
    check(cTag, "consumed", consumed, cons);
    for (int i = 0; i < cons; i++) void'(q.pop_front());
    @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0 || seqLeft > 0) step();
    step();
  endtask

  initial begin
    for (int i = 0; i < LANES; i++) eData[i] = '0;
    repeat (3) @(negedge clk);
    outTag = "R1";
    check("R1", "slotValid in reset", slotValid, 0);
    check("R1", "uopCount in reset", uopCount, 0);
    check("R1", "fromSeq in reset", fromSeq, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3/R4: full group of singles, then 4+1+1 = 6 micro-ops
    push(1); push(1); push(1);
    push(4); push(1); push(1);
    // R3: second lane needs 2 micro-ops, group stops after lane 0
    push(2); push(2); push(1);
    push(1); push(3); push(1);
    drain();

    // R5/R6: 9 micro-ops -> chunks 4,4,1 with singles waiting behind
    push(9); push(1); push(1);
    // R5 boundary: exactly 5 and exactly 8
    push(5); push(8); push(4); push(1);
    drain();

    // R7: stall in mid-sequence holds the position of a 10-micro-op instruction
    push(10); push(1); push(1);
    step();
    stallReq = 1; step(); step();
    stallReq = 0;
    drain();

    // R8: buffer presents fewer lanes than available
    availMax = 1; push(1); push(1); drain();
    availMax = 2; push(1); push(1); push(1); drain();
    availMax = 3;

    // Random mix
    for (int c = 0; c < 600; c++) begin
      if (q.size() < 6) begin
        int r = $urandom_range(0, 9);
        push(r < 7 ? 1 : (r < 9 ? $urandom_range(2, 4) : $urandom_range(5, 13)));
      end
      availMax = $urandom_range(0, 3);
      stallReq = ($urandom_range(0, 7) == 0);
      step();
    end
    stallReq = 0; availMax = 3;
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule